// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem-status register of a UART. It takes four active-low modem-control lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The block then reports each line's asserted state as an active-high level in the upper nibble of an 8-bit read value.

The lower nibble holds sticky change flags. The clear-to-send, data-set-ready and carrier-detect flags set on any change of their line. The ring-indicator flag sets only when its pin returns from low to high, which is the trailing edge of a ring. A host read of the register returns the flags and clears them. A change that arrives on the read cycle itself is not lost. When the modem-status interrupt is enabled, any set flag raises a level interrupt request. A clear-to-send change is left out of that request while automatic clear-to-send flow control is active.

A loopback control replaces the four pins with internally supplied levels, so that diagnostics can exercise the flags without external wiring. Interrupt priority encoding and the bus address decode sit outside this block.

Top module: `mdm_status_reg`

## Requirements
- R1: Read data bits 4, 5, 6 and 7 give the asserted state (1 when the pin is low) of clear-to-send, data-set-ready, ring indicator and carrier detect, in that order.
- R2: Bit 0 sets on any change of the clear-to-send level, bit 1 on any change of data-set-ready, and bit 3 on any change of carrier detect.
- R3: Bit 2 sets only when the ring-indicator pin goes from low to high, which is bit 6 going from 1 to 0. The opposite transition leaves bit 2 unchanged.
- R4: A set change flag stays set, whatever its line does afterwards, until the register is read.
- R5: A cycle with the read strobe high returns the current flags and clears all four on the following clock edge. A change detected on that same edge is set in the cleared flags.
- R6: The interrupt request is high exactly when the interrupt enable is high and a counted change flag is set. The request stays high until a read clears the flags.
- R7: While the auto-CTS input is high, bit 0 does not contribute to the interrupt request. Bit 0 itself still sets.
- R8: Reset clears both nibbles and the interrupt request. Pins held high through reset produce no flag after reset is released.
- R9: A pin change reaches the read data SYNC_STAGES+1 clock edges after it is first sampled, and no earlier.
- R10: With loopback high, `loop_bits` replaces the pins: bit 0 clear-to-send, bit 1 data-set-ready, bit 2 ring indicator, bit 3 carrier detect, each active-high. The loopback levels bypass the synchronizer and appear after one edge, and pin changes have no effect on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| rd_stb | input | 1 | Read strobe for this register, one cycle per read |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts_on | input | 1 | Automatic clear-to-send flow control active |
| loop_en | input | 1 | Loopback select |
| loop_bits | input | 4 | Loopback line levels, active high |
| rd_data | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request, level |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the latency check tell a three-stage chain apart from a two-stage one, and it exposes any place where the stage count is hard-coded. Directed steps land a data-set-ready change on the same edge as a read. They also drive both ring-indicator transitions, gate the interrupt through enable and auto-CTS, and switch into loopback while the pins move. A queue-based reference model is compared with the read data and the request on every clock.

// File: rtl/mdm_status_pkg.sv
package mdm_status_pkg;

   localparam int unsigned LANES    = 4;
   localparam int unsigned LANE_CTS = 0;
   localparam int unsigned LANE_DSR = 1;
   localparam int unsigned LANE_RI  = 2;
   localparam int unsigned LANE_DCD = 3;

   // Edge kinds act on the active-high level, not on the pin.
   typedef enum logic [1:0] {
      EDGE_ANY  = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_RISE = 2'd2
   } edge_kind_e;

   // The ring lane flags the end of a ring: pin low->high is level 1->0.
   function automatic edge_kind_e lane_edge(input int unsigned lane);
      return (lane == LANE_RI) ? EDGE_FALL : EDGE_ANY;
   endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= RST_VEC;
      else     stg[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VEC;
            else     stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_edge_detect.sv
module mdm_edge_detect
   import mdm_status_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_ANY
) (
   input  logic lvl_now,
   input  logic lvl_prev,
   output logic hit
);
   generate
      if (KIND == EDGE_FALL) begin : g_fall
         assign hit = lvl_prev & ~lvl_now;
      end else if (KIND == EDGE_RISE) begin : g_rise
         assign hit = ~lvl_prev & lvl_now;
      end else begin : g_any
         assign hit = lvl_prev ^ lvl_now;
      end
   endgenerate
endmodule

// File: rtl/mdm_flag_bank.sv
module mdm_flag_bank #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [WIDTH-1:0] set,
   output logic [WIDTH-1:0] flg
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mdm_flag_bank: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_flag
         // A set that lands with the clear wins, so no change is lost.
         always_ff @(posedge clk) begin
            if (rst)      flg[i] <= 1'b0;
            else if (clr) flg[i] <= set[i];
            else          flg[i] <= flg[i] | set[i];
         end
      end
   endgenerate
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
   import mdm_status_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cts_n,
   input  logic             dsr_n,
   input  logic             ri_n,
   input  logic             dcd_n,
   input  logic             rd_stb,
   input  logic             msi_en,
   input  logic             auto_cts_on,
   input  logic             loop_en,
   input  logic [LANES-1:0] loop_bits,
   output logic [7:0]       rd_data,
   output logic             irq
);
   localparam int unsigned RD_W = 2 * LANES;

   generate
      if (RD_W != 8) begin : g_bad_lanes
         $error("mdm_status_reg: lane count must fill one byte");
      end
   endgenerate

   logic [LANES-1:0] pin_raw;
   logic [LANES-1:0] pin_sync;
   logic [LANES-1:0] lvl_now;
   logic [LANES-1:0] lvl_q;
   logic [LANES-1:0] chg;
   logic [LANES-1:0] flg;
   logic [LANES-1:0] irq_mask;

   assign pin_raw = {dcd_n, ri_n, dsr_n, cts_n};

   mdm_sync #(
      .WIDTH   (LANES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_raw),
      .q   (pin_sync)
   );

   assign lvl_now = loop_en ? loop_bits : ~pin_sync;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_now;
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         mdm_edge_detect #(
            .KIND (lane_edge(i))
         ) u_edge (
            .lvl_now  (lvl_now[i]),
            .lvl_prev (lvl_q[i]),
            .hit      (chg[i])
         );
      end
   endgenerate

   mdm_flag_bank #(
      .WIDTH (LANES)
   ) u_flags (
      .clk (clk),
      .rst (rst),
      .clr (rd_stb),
      .set (chg),
      .flg (flg)
   );

   always_comb begin
      irq_mask           = '1;
      irq_mask[LANE_CTS] = ~auto_cts_on;
   end

   assign irq     = msi_en & (|(flg & irq_mask));
   assign rd_data = {lvl_q, flg};
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
   input logic       clk,
   input logic       rst,
   input logic       rd_stb,
   input logic       msi_en,
   input logic       auto_cts_on,
   input logic [7:0] rd_data,
   input logic       irq
);
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
      !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R4

   AST_CTS_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_data[0]) |-> (rd_data[4] != $past(rd_data[4]))); // R2

   AST_RI_TRAILING_ONLY: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_data[2]) |-> $fell(rd_data[6])); // R3

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      !msi_en |-> !irq); // R6

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      irq |-> (rd_data[3:0] != 4'h0)); // R6

   AST_AUTO_CTS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (auto_cts_on && rd_data[3:1] == 3'b000) |-> !irq); // R7

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (irq && !rd_stb && $stable(msi_en) && $stable(auto_cts_on)) |=> irq); // R6
endmodule

bind mdm_status_reg mdm_status_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .rd_stb      (rd_stb),
   .msi_en      (msi_en),
   .auto_cts_on (auto_cts_on),
   .rd_data     (rd_data),
   .irq         (irq)
);

// File: tb/mdm_status_reg_bench.sv
module mdm_status_reg_bench;
   localparam int N = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       rd_stb = 1'b0, msi_en = 1'b0, auto_cts_on = 1'b0, loop_en = 1'b0;
   logic [3:0] loop_bits = 4'h0;
   logic [7:0] rd_data;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mdm_status_reg #(.SYNC_STAGES(N)) u_mdm_status_reg (
      .clk (clk), .rst (rst),
      .cts_n (cts_n), .dsr_n (dsr_n), .ri_n (ri_n), .dcd_n (dcd_n),
      .rd_stb (rd_stb), .msi_en (msi_en), .auto_cts_on (auto_cts_on),
      .loop_en (loop_en), .loop_bits (loop_bits),
      .rd_data (rd_data), .irq (irq)
   );

   // Reference model: pin history queue, levels and flags as plain values.
   logic [3:0] hist [$];
   logic [3:0] m_lvl = 4'h0;
   logic [3:0] m_flg = 4'h0;

   initial begin
      for (int i = 0; i < N; i++) hist.push_back(4'hF);
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      logic [3:0] sv, nv, ch;
      logic       m_irq;
      if (!done && !rst) begin
         m_irq = msi_en & (|(m_flg & {3'b111, ~auto_cts_on}));
         chk("R1 levels", {4'h0, rd_data[7:4]}, {4'h0, m_lvl});
         chk("R2 flags", {4'h0, rd_data[3:0]}, {4'h0, m_flg});
         chk("R6 irq", {7'h0, irq}, {7'h0, m_irq});
      end
      if (rst) begin
         hist = {};
         for (int i = 0; i < N; i++) hist.push_back(4'hF);
         m_lvl <= 4'h0;
         m_flg <= 4'h0;
      end else begin
         sv = hist.pop_front();
         hist.push_back({dcd_n, ri_n, dsr_n, cts_n});
         nv = loop_en ? loop_bits : ~sv;
         ch = nv ^ m_lvl;
         ch[2] = m_lvl[2] & ~nv[2];
         m_lvl <= nv;
         m_flg <= (rd_stb ? 4'h0 : m_flg) | ch;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(input logic [7:0] exp, input string tag);
      rd_stb = 1'b1;
      #1 chk(tag, rd_data, exp);
      tick(1);
      rd_stb = 1'b0;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      chk("R8 reset rd_data", rd_data, 8'h00);
      chk("R8 reset irq", {7'h0, irq}, 8'h00);
      tick(N + 2);
      chk("R8 no flag after reset", rd_data, 8'h00);

      cts_n = 1'b0;
      tick(N);
      chk("R9 not yet visible", rd_data, 8'h00);
      tick(1);
      chk("R9 R1 R2 cts change", rd_data, 8'h11);
      do_read(8'h11, "R5 read returns flags");
      chk("R5 flags cleared", rd_data, 8'h10);

      ri_n = 1'b0;
      tick(N + 1);
      chk("R3 ri leading edge no flag", rd_data, 8'h50);
      ri_n = 1'b1;
      tick(N + 1);
      chk("R3 ri trailing edge flag", rd_data, 8'h14);
      #1 chk("R6 irq off when disabled", {7'h0, irq}, 8'h00);
      msi_en = 1'b1;
      #1 chk("R6 irq on when enabled", {7'h0, irq}, 8'h01);
      tick(5);
      chk("R6 irq level holds", {7'h0, irq}, 8'h01);
      do_read(8'h14, "R5 read ri flag");
      #1 chk("R6 irq clears on read", {7'h0, irq}, 8'h00);

      auto_cts_on = 1'b1;
      cts_n = 1'b1;
      tick(N + 1);
      chk("R7 cts flag still sets", rd_data, 8'h01);
      #1 chk("R7 cts irq suppressed", {7'h0, irq}, 8'h00);
      auto_cts_on = 1'b0;
      #1 chk("R7 cts irq without auto", {7'h0, irq}, 8'h01);

      tick(10);
      chk("R4 flag sticky", rd_data, 8'h01);

      dsr_n = 1'b0;
      tick(N);
      rd_stb = 1'b1;
      #1 chk("R5 read before collision", rd_data, 8'h01);
      tick(1);
      rd_stb = 1'b0;
      chk("R5 change on read cycle kept", rd_data, 8'h22);

      dcd_n = 1'b0;
      tick(N + 1);
      chk("R2 dcd change", rd_data, 8'hAA);
      do_read(8'hAA, "R5 read dcd");
      chk("R5 cleared after dcd", rd_data, 8'hA0);

      loop_en = 1'b1;
      loop_bits = 4'b0100;
      tick(1);
      chk("R10 loopback one edge", rd_data, 8'h4A);
      loop_bits = 4'b0000;
      cts_n = 1'b0;
      tick(1);
      chk("R10 R3 loopback ri trailing", rd_data, 8'h0E);
      tick(N + 2);
      chk("R10 pins ignored in loopback", rd_data, 8'h0E);

      rst = 1'b1;
      tick(1);
      rst = 1'b0;
      chk("R8 reset clears after use", rd_data, 8'h00);
      #1 chk("R8 reset clears irq", {7'h0, irq}, 8'h00);
      loop_en = 1'b0;
      tick(N + 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule